// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serializes bytes onto a single asynchronous line. The line rests high. Software places a character into a one-entry holding register. The character moves into a frame shift register as soon as that register has finished its previous frame. The frame is then sent bit by bit, and a one-cycle baud strobe from an external rate generator marks each bit boundary. Because the holding register and the shift register are separate, the next character can be queued while the current one is still on the wire. Frames can then follow each other with almost no idle gap.

Three outputs report the state of the transmitter. The empty flag tells software that the holding register can take a write. The complete flag tells software that the line has gone quiet after the last stop bit. The effective-enable output shows whether the transmitter is still running. A request to turn the transmitter off is deferred until both registers have drained.

Top module: `ser_tx_dbuf`

## Requirements
- R1: Out of reset, and at any time no frame is in progress, `txLine` is high. In reset, `dreFlag`, `txcFlag` and `txEnabled` are low.
- R2: A write (`wrValid` high while `dreFlag` is high) fills the holding register. Its contents move to the shift register one cycle after the shift register becomes idle, never while a frame is in progress. After the move, `dreFlag` rises again.
- R3: A frame consists of a low start bit, then the data bits least significant first, then an optional parity bit, then one (`cfgTwoStop`=0) or two (`cfgTwoStop`=1) high stop bits. The number of data bits comes from `cfgDataBits`: values below 5 act as 5, and values above 9 act as 9. The start bit appears on the cycle after the load. Each bit then holds until the next `baudTick`.
- R4: `txcFlag` sets when the last stop bit ends and the holding register is empty. It does not set at the end of a frame while a character is waiting.
- R5: `txcFlag` clears on a `txcClear` pulse and also on an accepted write.
- R6: A write while `dreFlag` is low is ignored, and the character already waiting is sent unchanged.
- R7: When `txEnable` goes low, `txEnabled` stays high until the shift register and the holding register are both empty. The waiting and in-flight frames are sent in full.
- R8: `dreFlag` is high only while the transmitter is enabled and the holding register is empty. Writes while disabled are ignored and start no frame.
- R9: The frame configuration (`cfgDataBits`, `cfgParityEn`, `cfgParityOdd`, `cfgTwoStop`) is sampled when a character is loaded. Changes in mid-frame do not alter that frame. With `cfgParityEn` high, `cfgParityOdd`=0 selects even parity and `cfgParityOdd`=1 selects odd parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnable | input | 1 | Transmitter enable request |
| cfgDataBits | input | 4 | Data bits per frame (clamped to 5..9) |
| cfgParityEn | input | 1 | Append a parity bit |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even |
| cfgTwoStop | input | 1 | 1 = two stop bits |
| baudTick | input | 1 | One-cycle bit-boundary strobe |
| wrValid | input | 1 | Write strobe for the holding register |
| wrData | input | 9 | Character to send |
| txcClear | input | 1 | Clear transmit-complete |
| txLine | output | 1 | Serial output, idles high |
| dreFlag | output | 1 | Holding register empty and writable |
| txcFlag | output | 1 | Transmit complete |
| txEnabled | output | 1 | Effective enable state |

## Verification
Some properties are checked by assertions on every cycle: the idle-high line, the low start bit at the beginning of every frame, the non-zero bit count while a frame is in progress, and the transmit-complete flag appearing only with both registers empty. The assertions also check that the enable cannot drop while data is pending. Other behaviour shows only in the bench's scenarios. These are the exact bit order and parity of each frame shape, a character queued behind a frame in flight, a rejected write while full, a configuration change in mid-frame, and a full drain sequence before the transmitter goes off.

// File: rtl/serTxPkg.sv
package serTxPkg;
  typedef struct packed {
    logic captureHold;
    logic loadShift;
    logic shiftOut;
  } txStrobeT;
endpackage

// File: rtl/serTxCtrl.sv
module serTxCtrl #(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 txEnable,
  input  logic                 baudTick,
  input  logic                 wrValid,
  input  logic                 txcClear,
  input  logic [CNT_W-1:0]     frameLen,
  output serTxPkg::txStrobeT   strobe,
  output logic                 busy,
  output logic                 dreFlag,
  output logic                 txcFlag,
  output logic                 txEnabled
);
  logic             holdFull;
  logic [CNT_W-1:0] bitsLeft;
  logic             wrAccept, loadNow, lastBit;

  assign wrAccept = wrValid && txEnabled && !holdFull;
  assign loadNow  = holdFull && !busy && txEnabled;
  assign lastBit  = busy && baudTick && (bitsLeft == CNT_W'(1));

  assign strobe.captureHold = wrAccept;
  assign strobe.loadShift   = loadNow;
  assign strobe.shiftOut    = busy && baudTick;
  assign dreFlag            = txEnabled && !holdFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEnabled <= 1'b0;
      holdFull  <= 1'b0;
      busy      <= 1'b0;
      bitsLeft  <= '0;
      txcFlag   <= 1'b0;
    end else begin
      txEnabled <= txEnable || (txEnabled && (holdFull || busy));
      if (wrAccept)     holdFull <= 1'b1;
      else if (loadNow) holdFull <= 1'b0;
      if (loadNow) begin
        busy     <= 1'b1;
        bitsLeft <= frameLen;
      end else if (busy && baudTick) begin
        bitsLeft <= bitsLeft - CNT_W'(1);
        if (bitsLeft == CNT_W'(1)) busy <= 1'b0;
      end
      if (lastBit && !holdFull && !wrAccept) txcFlag <= 1'b1;
      else if (wrAccept || txcClear)         txcFlag <= 1'b0;
    end
  end

  assert_txc_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    txcFlag |-> (!busy && !holdFull));
  assert_drain_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txEnabled && (busy || holdFull)) |=> txEnabled);
  assert_count_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft != '0));
  assert_load_after_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(holdFull));
endmodule

// File: rtl/serTxData.sv
module serTxData #(
  parameter int DATA_W = 9,
  parameter int MIN_DATA = 5,
  parameter int DBITS_W = 4,
  parameter int FRAME_W = 13,
  parameter int CNT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  serTxPkg::txStrobeT  strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DBITS_W-1:0]  cfgDataBits,
  input  logic                cfgParityEn,
  input  logic                cfgParityOdd,
  input  logic                cfgTwoStop,
  output logic [CNT_W-1:0]    frameLen,
  output logic                txLine
);
  logic [DATA_W-1:0]  holdData;
  logic [FRAME_W-1:0] shiftReg;
  logic [FRAME_W-1:0] frameNext;
  logic [DBITS_W-1:0] ndEff;
  logic               parBit;

  always_comb begin
    if (cfgDataBits < DBITS_W'(MIN_DATA))    ndEff = DBITS_W'(MIN_DATA);
    else if (cfgDataBits > DBITS_W'(DATA_W)) ndEff = DBITS_W'(DATA_W);
    else                                     ndEff = cfgDataBits;
  end

  always_comb begin
    parBit    = cfgParityOdd;
    frameNext = '1;
    frameNext[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(ndEff)) begin
        frameNext[1+i] = holdData[i];
        parBit = parBit ^ holdData[i];
      end
    end
    if (cfgParityEn) frameNext[1 + int'(ndEff)] = parBit;
  end

  assign frameLen = CNT_W'(1) + CNT_W'(ndEff) + CNT_W'(cfgParityEn)
                  + (cfgTwoStop ? CNT_W'(2) : CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      shiftReg <= '1;
    end else begin
      if (strobe.captureHold) holdData <= wrData;
      if (strobe.loadShift)     shiftReg <= frameNext;
      else if (strobe.shiftOut) shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  assign txLine = shiftReg[0];

  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadShift && strobe.shiftOut));
endmodule

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int DATA_W = 9,
  parameter int MIN_DATA = 5,
  parameter int MAX_STOP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic [3:0]        cfgDataBits,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgTwoStop,
  input  logic              baudTick,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txcClear,
  output logic              txLine,
  output logic              dreFlag,
  output logic              txcFlag,
  output logic              txEnabled
);
  localparam int FRAME_W = 1 + DATA_W + 1 + MAX_STOP;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  serTxPkg::txStrobeT strobe;
  logic [CNT_W-1:0]   frameLen;
  logic               busy;

  serTxCtrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .wrValid(wrValid), .txcClear(txcClear), .frameLen(frameLen),
    .strobe(strobe), .busy(busy), .dreFlag(dreFlag), .txcFlag(txcFlag),
    .txEnabled(txEnabled)
  );

  serTxData #(.DATA_W(DATA_W), .MIN_DATA(MIN_DATA), .DBITS_W(4),
              .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .frameLen(frameLen), .txLine(txLine)
  );

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);
  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !txLine);
endmodule

// File: tb/test_ser_tx_dbuf.sv
module test_ser_tx_dbuf;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnable = 1'b1, cfgParityEn = 1'b0, cfgParityOdd = 1'b0, cfgTwoStop = 1'b0;
  logic [3:0] cfgDataBits = 4'd8;
  logic baudTick = 1'b0, wrValid = 1'b0, txcClear = 1'b0;
  logic [8:0] wrData = '0;
  logic txLine, dreFlag, txcFlag, txEnabled;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ser_tx_dbuf i_ser_tx_dbuf (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .cfgDataBits(cfgDataBits),
    .cfgParityEn(cfgParityEn), .cfgParityOdd(cfgParityOdd), .cfgTwoStop(cfgTwoStop),
    .baudTick(baudTick), .wrValid(wrValid), .wrData(wrData), .txcClear(txcClear),
    .txLine(txLine), .dreFlag(dreFlag), .txcFlag(txcFlag), .txEnabled(txEnabled)
  );

  typedef struct packed {
    logic [8:0] data;
    logic [3:0] nd;
    logic       par;
    logic       odd;
    logic       two;
    logic [3:0] len;
  } vecT;

  localparam vecT VECS [0:6] = '{
    '{9'h055, 4'd8,  1'b0, 1'b0, 1'b0, 4'd10},
    '{9'h0A5, 4'd8,  1'b1, 1'b0, 1'b0, 4'd11},
    '{9'h013, 4'd5,  1'b1, 1'b1, 1'b1, 4'd9},
    '{9'h1FF, 4'd9,  1'b1, 1'b1, 1'b1, 4'd13},
    '{9'h0F0, 4'd7,  1'b1, 1'b0, 1'b0, 4'd10},
    '{9'h1A5, 4'd12, 1'b0, 1'b0, 1'b1, 4'd12},
    '{9'h000, 4'd3,  1'b1, 1'b0, 1'b0, 4'd8}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] expFrame(input logic [8:0] d, input int nd,
                                           input bit par, input bit odd, input bit two);
    logic [12:0] f = '1;
    int idx = 1;
    int n = (nd < 5) ? 5 : ((nd > 9) ? 9 : nd);
    logic p = odd;
    f[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      f[idx] = d[i];
      p = p ^ d[i];
      idx++;
    end
    if (par) begin f[idx] = p; idx++; end
    f[idx] = 1'b1;
    if (two) f[idx+1] = 1'b1;
    return f;
  endfunction

  task automatic tick();
    baudTick = 1'b1;
    @(negedge clk);
    baudTick = 1'b0;
  endtask

  task automatic writeByte(input logic [8:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic captureFrame(input int len, output logic [12:0] got);
    got = '1;
    for (int i = 0; i < len; i++) begin
      got[i] = txLine;
      @(negedge clk);
      if (txLine != got[i]) got[i] = ~got[i];
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] got, exp, got2;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(txLine && !dreFlag && !txcFlag && !txEnabled, "R1 reset state",
          {txLine, dreFlag, txcFlag, txEnabled}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(dreFlag && txEnabled, "R8 enabled and empty after reset", {dreFlag, txEnabled}, 2'b11);

    // R3/R9 table of frame shapes
    for (int v = 0; v < 7; v++) begin
      cfgDataBits  = VECS[v].nd;
      cfgParityEn  = VECS[v].par;
      cfgParityOdd = VECS[v].odd;
      cfgTwoStop   = VECS[v].two;
      writeByte(VECS[v].data);
      if (v > 0) check(!txcFlag, "R5 write clears complete", txcFlag, 0);
      @(negedge clk);
      captureFrame(int'(VECS[v].len), got);
      exp = expFrame(VECS[v].data, int'(VECS[v].nd), VECS[v].par, VECS[v].odd, VECS[v].two);
      check(got == exp, "R3 frame bits", got, exp);
      check(txcFlag, "R4 complete after last stop", txcFlag, 1);
      check(txLine, "R1 idle high after frame", txLine, 1);
    end

    // R5: clear by pulse
    @(negedge clk);
    txcClear = 1'b1;
    @(negedge clk);
    txcClear = 1'b0;
    check(!txcFlag, "R5 clear pulse", txcFlag, 0);

    // R2/R4/R6: queue behind a frame, rejected write while full
    cfgDataBits = 4'd8; cfgParityEn = 1'b0; cfgTwoStop = 1'b0;
    writeByte(9'h03C);
    @(negedge clk);
    check(dreFlag, "R2 holding empty after load", dreFlag, 1);
    writeByte(9'h0C3);
    check(!dreFlag, "R2 holding full", dreFlag, 0);
    writeByte(9'h0FF);
    captureFrame(10, got);
    exp = expFrame(9'h03C, 8, 1'b0, 1'b0, 1'b0);
    check(got == exp, "R2 first frame", got, exp);
    check(!txcFlag, "R4 no complete while pending", txcFlag, 0);
    @(negedge clk);
    check(!txLine && dreFlag, "R2 second frame started", {txLine, dreFlag}, 2'b01);
    captureFrame(10, got);
    exp = expFrame(9'h0C3, 8, 1'b0, 1'b0, 1'b0);
    check(got == exp, "R6 waiting byte kept", got, exp);
    check(txcFlag, "R4 complete after drain", txcFlag, 1);

    // R9: configuration change in mid-frame
    writeByte(9'h05A);
    @(negedge clk);
    got = '1;
    got[0] = txLine;
    tick();
    cfgDataBits = 4'd5; cfgParityEn = 1'b1; cfgParityOdd = 1'b1; cfgTwoStop = 1'b1;
    captureFrame(9, got2);
    got[9:1] = got2[8:0];
    exp = expFrame(9'h05A, 8, 1'b0, 1'b0, 1'b0);
    check(got == exp, "R9 config sampled at load", got, exp);
    repeat (3) begin @(negedge clk); tick(); end
    check(txLine, "R9 no extra bits", txLine, 1);

    // R7/R8: deferred disable
    cfgDataBits = 4'd8; cfgParityEn = 1'b0; cfgTwoStop = 1'b0;
    writeByte(9'h081);
    @(negedge clk);
    writeByte(9'h018);
    txEnable = 1'b0;
    @(negedge clk);
    check(txEnabled, "R7 enable held while pending", txEnabled, 1);
    captureFrame(10, got);
    @(negedge clk);
    captureFrame(10, got);
    exp = expFrame(9'h018, 8, 1'b0, 1'b0, 1'b0);
    check(got == exp, "R7 pending frame sent in full", got, exp);
    repeat (2) @(negedge clk);
    check(!txEnabled && !dreFlag, "R7 disabled after drain", {txEnabled, dreFlag}, 2'b00);
    check(txcFlag, "R4 complete before disable", txcFlag, 1);
    writeByte(9'h000);
    got = '1;
    for (int i = 0; i < 4; i++) begin
      got[i] = txLine;
      tick();
    end
    check(got == 13'h1FFF, "R8 write ignored while disabled", got, 13'h1FFF);
    txEnable = 1'b1;
    @(negedge clk);
    check(dreFlag && txEnabled && txLine, "R8 re-enable empty", {dreFlag, txEnabled, txLine}, 3'b111);
    check(txcFlag, "R5 flag held until cleared", txcFlag, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule